// File: doc/BRIEF.md
# Dual-Output Centre-Aligned PWM Generator

This block produces two pulse-width-modulated outputs from one shared up-down time-base counter. The counter climbs from zero to a programmable period and then falls back to zero. This gives a symmetric, centre-aligned carrier. Each output has its own compare value and its own pair of actions: one action for a match on the rising slope and one for a match on the falling slope. One output can therefore follow a changing duty cycle while the other runs a fixed duty cycle or is parked at a static level.

Software reaches the block through a plain register write strobe. The period and both compare values are written to shadow copies. A shadow reaches the active register only while the counter is zero, so a write never tears the current carrier period. The action codes take effect at once. A latching trip drives both outputs low. The trip can come from an external level source or from a one-cycle force pulse, and it holds until a clear pulse arrives while no source is active. A run enable holds the counter at zero and both outputs low while it is low. The counter value and the slope direction are exported for use by neighbouring logic.

The write port is a simple strobe that is always accepted. The block has no data stream, so no valid/ready handshake is needed and the block never applies back-pressure. All other pins are plain control and status levels.

Top module: `pwm_dual_sym`

## Requirements
- R1: While enabled, the counter steps 0,1,…,P,P-1,…,1,0,1,… where P is the active period. `cnt_down` is 1 at every zero and on the falling slope, and 0 from 1 up to and including P. The turn at P happens on the clock after P is reached. If P is 0, the counter stays at 0.
- R2: The period resets to 2500. A write to address 0 loads only the period shadow. The shadow is copied to the active period on each clock edge at which the counter is 0.
- R3: The compare values reset to 500 for output A and 1000 for output B. Writes to address 1 (A) and address 2 (B) load only the shadows. Each shadow is copied to its active compare at clock edges where the counter is 0.
- R4: A match occurs when the counter equals min(compare, P). A match at P counts only as a rising-slope match. A match at 0 counts only as a falling-slope match.
- R5: Address 3 (A) and address 4 (B) hold a 4-bit action word. Bits [1:0] are the rising-slope action and bits [3:2] are the falling-slope action. The codes are 00 hold, 01 drive low, 10 drive high and 11 invert. The chosen action shows on the output one clock after the matching counter value.
- R6: With the reset action word 0110 (rising = high, falling = low) and 0 < C < P, the output is high for 2·(P−C) of every 2·P cycles and changes level exactly twice per period.
- R7: A compare of 0 gives a constant low output. A compare of P or more gives a constant high output. Neither case produces any edge once the output has settled.
- R8: Outputs A and B follow only their own compare and action settings. Changing one output's settings has no effect on the other output.
- R9: A high level on `trip_src`, or a one-cycle pulse on `trip_force`, drives both outputs low from the next sampled cycle.
- R10: The trip stays latched after its cause goes away. A `trip_clr` pulse is ignored while `trip_src` or `trip_force` is high.
- R11: After a trip is cleared, both outputs stay low until their next compare action drives them.
- R12: While `en` is low, the counter is 0, `cnt_down` is 1, and both outputs are low from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter at zero and the outputs low |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | 3 | Register select: 0 period, 1 compare A, 2 compare B, 3 actions A, 4 actions B |
| wr_data | input | CW (16) | Write data; action words use bits [3:0] |
| trip_src | input | 1 | Level trip source |
| trip_force | input | 1 | Software trip pulse |
| trip_clr | input | 1 | Trip clear pulse |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cnt | output | CW (16) | Time-base counter value |
| cnt_down | output | 1 | Counter slope: 1 falling or at zero, 0 rising |

## Verification
The bench targets the extreme compare values of zero, the period, and above the period. A design that counted a match twice at a turning point would emit a short glitch or settle at the wrong constant level in these cases. Compare and period values are rewritten in the middle of a period. Letting a shadow pass through early would move an edge within the current period or shorten the carrier. The trip is tested while a source is still held and right after clearing. A design that accepted the clear too early, or that restored the pre-trip level instead of waiting for the next compare action, would show a high output where the bench expects low. Inverted and parked action codes on one output, with normal modulation on the other, expose any cross-coupling between the two channels.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // [3:2] falling-slope action, [1:0] rising-slope action
  typedef struct packed {
    act_e dn;
    act_e up;
  } act_pair_t;

  localparam act_pair_t ACT_DEFAULT = '{dn: ACT_CLR, up: ACT_SET};

  localparam int AW = 3;
  localparam logic [AW-1:0] ADDR_PRD  = 3'd0;
  localparam logic [AW-1:0] ADDR_CMPA = 3'd1;
  localparam logic [AW-1:0] ADDR_ACTA = 3'd3;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW      = 16,
  parameter int PRD_RST = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          prd_wr,
  input  logic [CW-1:0] prd_wdata,
  output logic [CW-1:0] cnt_o,
  output logic          down_o,
  output logic          zero_o,
  output logic [CW-1:0] prd_o
);

  localparam logic [CW-1:0] PRD_INIT = CW'(PRD_RST);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] prd_sh, prd_act, cnt_q, prd_use;
  logic          down_q, zero;

  assign zero    = (cnt_q == '0);
  assign prd_use = zero ? prd_sh : prd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= PRD_INIT;
      prd_act <= PRD_INIT;
    end else begin
      if (prd_wr) prd_sh <= prd_wdata;
      if (zero)   prd_act <= prd_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b1;
    end else if (!en) begin
      cnt_q  <= '0;
      down_q <= 1'b1;
    end else if (down_q) begin
      if (zero) begin
        if (prd_use != '0) begin
          cnt_q  <= ONE;
          down_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end else begin
      if (cnt_q >= prd_act) begin
        cnt_q  <= cnt_q - ONE;
        down_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;
  assign zero_o = zero;
  assign prd_o  = prd_act;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_act) else $error("counter above period"); // R1
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down_q && cnt_q == prd_act) |=> down_q) else $error("no turn at top"); // R1
  AST_ZERO_IS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> down_q) else $error("zero seen on rising slope"); // R4
  AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> $stable(prd_act)) else $error("period changed mid-count"); // R2
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && down_q)) else $error("counter ran while disabled"); // R12

endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
  import pwm_dual_pkg::*;
#(
  parameter int CW      = 16,
  parameter int CMP_RST = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trip,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          act_wr,
  input  act_pair_t     act_wdata,
  input  logic [CW-1:0] cnt,
  input  logic          down,
  input  logic          zero,
  input  logic [CW-1:0] prd,
  output logic          out_o
);

  localparam logic [CW-1:0] CMP_INIT = CW'(CMP_RST);

  logic [CW-1:0] cmp_sh, cmp_act, cmp_eff;
  act_pair_t     act_q;
  act_e          sel;
  logic          hit, up_hit, dn_hit, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh  <= CMP_INIT;
      cmp_act <= CMP_INIT;
      act_q   <= ACT_DEFAULT;
    end else begin
      if (cmp_wr) cmp_sh <= cmp_wdata;
      if (zero)   cmp_act <= cmp_sh;
      if (act_wr) act_q <= act_wdata;
    end
  end

  // compare at or past the period saturates to the top turning point
  assign cmp_eff = (cmp_act >= prd) ? prd : cmp_act;
  assign hit     = (cnt == cmp_eff);
  assign up_hit  = hit && !down;
  assign dn_hit  = hit && down;

  always_comb begin
    sel = ACT_NONE;
    if (up_hit)      sel = act_q.up;
    else if (dn_hit) sel = act_q.dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (!en || trip) begin
      out_q <= 1'b0;
    end else begin
      case (sel)
        ACT_CLR: out_q <= 1'b0;
        ACT_SET: out_q <= 1'b1;
        ACT_TGL: out_q <= ~out_q;
        default: out_q <= out_q;
      endcase
    end
  end

  assign out_o = out_q;

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> $stable(cmp_act)) else $error("compare changed mid-count"); // R3
  AST_TRIP_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !out_q) else $error("output active under trip"); // R9
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_q) else $error("output active while disabled"); // R12
  AST_QUIET_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !trip && !hit) |=> $stable(out_q)) else $error("edge without match"); // R5

endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic force_i,
  input  logic clr,
  output logic trip_o
);

  logic trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             trip_q <= 1'b0;
    else if (src || force_i) trip_q <= 1'b1;
    else if (clr)           trip_q <= 1'b0;
  end

  assign trip_o = trip_q;

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr) |=> trip_q) else $error("trip released without clear"); // R10
  AST_TRIP_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (src || force_i) |=> trip_q) else $error("trip cause missed"); // R9

endmodule

// File: rtl/pwm_dual_sym.sv
module pwm_dual_sym
  import pwm_dual_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PRD_RST  = 2500,
  parameter int CMPA_RST = 500,
  parameter int CMPB_RST = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trip_src,
  input  logic          trip_force,
  input  logic          trip_clr,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [CW-1:0] cnt,
  output logic          cnt_down
);

  localparam int NCH = 2;

  logic [CW-1:0]  tb_cnt, tb_prd;
  logic           tb_down, tb_zero, tripped;
  logic [NCH-1:0] ch_out;

  pwm_timebase #(.CW(CW), .PRD_RST(PRD_RST)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .prd_wr    (wr_en && (wr_addr == ADDR_PRD)),
    .prd_wdata (wr_data),
    .cnt_o     (tb_cnt),
    .down_o    (tb_down),
    .zero_o    (tb_zero),
    .prd_o     (tb_prd)
  );

  pwm_trip_latch u_trip (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (trip_src),
    .force_i (trip_force),
    .clr     (trip_clr),
    .trip_o  (tripped)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int RST_V = (g == 0) ? CMPA_RST : CMPB_RST;
    logic cmp_wr, act_wr;
    assign cmp_wr = wr_en && (wr_addr == ADDR_CMPA + 3'(g));
    assign act_wr = wr_en && (wr_addr == ADDR_ACTA + 3'(g));

    pwm_out_chan #(.CW(CW), .CMP_RST(RST_V)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .trip      (tripped),
      .cmp_wr    (cmp_wr),
      .cmp_wdata (wr_data),
      .act_wr    (act_wr),
      .act_wdata (act_pair_t'(wr_data[3:0])),
      .cnt       (tb_cnt),
      .down      (tb_down),
      .zero      (tb_zero),
      .prd       (tb_prd),
      .out_o     (ch_out[g])
    );
  end

  // the trip also gates the pins so they fall in the same cycle the latch sets
  assign pwm_a    = ch_out[0] & ~tripped;
  assign pwm_b    = ch_out[1] & ~tripped;
  assign cnt      = tb_cnt;
  assign cnt_down = tb_down;

endmodule

// File: tb/pwm_dual_sym_tb.sv
module pwm_dual_sym_tb;

  localparam int CLK_P = 10;
  localparam int CW    = 16;
  localparam int NV    = 8;
  // period, cmpA, cmpB, actA, actB, highA, edgesA, highB, edgesB (per 2P window)
  localparam int VT [NV][9] = '{
    '{10,  3,  7,  6, 6, 14, 2,  6, 2},
    '{10,  0, 10,  6, 6,  0, 0, 20, 0},
    '{10, 15,  5,  6, 6, 20, 0, 10, 2},
    '{ 8,  2,  2,  6, 9, 12, 2,  4, 2},
    '{ 8,  4,  4, 15, 0,  8, 2,  0, 0},
    '{12,  6,  3,  2, 5, 24, 0,  0, 0},
    '{ 6,  1,  5,  6, 6, 10, 2,  2, 2},
    '{ 1,  1,  0,  6, 6,  2, 0,  0, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          trip_src = 1'b0, trip_force = 1'b0, trip_clr = 1'b0;
  logic          pwm_a, pwm_b, cnt_down;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_bad = 0;

  pwm_dual_sym u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trip_src(trip_src), .trip_force(trip_force),
    .trip_clr(trip_clr), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt),
    .cnt_down(cnt_down)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_for(input int v, input logic d);
    int n = 0;
    while (!(cnt == CW'(v) && cnt_down == d) && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 6000) chk("wait_for counter value", 0, 1);
  endtask

  task automatic setup(input int p, input int ca, input int cb, input int aa, input int ab);
    en = 1'b0;
    @(negedge clk);
    wr(0, p); wr(1, ca); wr(2, cb); wr(3, aa); wr(4, ab);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R12 reset cnt", int'(cnt), 0);
    chk("R12 reset cnt_down", int'(cnt_down), 1);
    chk("R12 reset pwm_a", int'(pwm_a), 0);
    chk("R12 reset pwm_b", int'(pwm_b), 0);

    // defaults: P=2500, A=500, B=1000
    en = 1'b1;
    wait_for(501, 1'b0);
    chk("R3 default cmpA rise", int'(pwm_a), 1);
    chk("R3 default cmpB not yet", int'(pwm_b), 0);
    wait_for(1001, 1'b0);
    chk("R3 default cmpB rise", int'(pwm_b), 1);
    wait_for(2500, 1'b0);
    @(negedge clk);
    chk("R2 default period turn", int'(cnt), 2499);
    chk("R1 falling flag", int'(cnt_down), 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int p, ha, ea, hb, eb;
      logic pa, pb;
      p = VT[v][0];
      setup(p, VT[v][1], VT[v][2], VT[v][3], VT[v][4]);
      en = 1'b1;
      repeat (4 * p) @(negedge clk);
      ha = 0; ea = 0; hb = 0; eb = 0;
      pa = pwm_a; pb = pwm_b;
      for (int i = 0; i < 2 * p; i++) begin
        @(negedge clk);
        ha += int'(pwm_a); hb += int'(pwm_b);
        if (pwm_a != pa) ea++;
        if (pwm_b != pb) eb++;
        pa = pwm_a; pb = pwm_b;
      end
      chk($sformatf("R6 R7 R5 vec%0d A high", v), ha, VT[v][5]);
      chk($sformatf("R6 R7 R4 vec%0d A edges", v), ea, VT[v][6]);
      chk($sformatf("R8 R5 vec%0d B high", v), hb, VT[v][7]);
      chk($sformatf("R8 R7 vec%0d B edges", v), eb, VT[v][8]);
    end

    // counter sequence P=3
    begin
      int ec [8] = '{0, 1, 2, 3, 2, 1, 0, 1};
      int ed [8] = '{1, 0, 0, 0, 1, 1, 1, 0};
      setup(3, 1, 2, 6, 6);
      en = 1'b1;
      for (int k = 0; k < 8; k++) begin
        chk($sformatf("R1 seq cnt %0d", k), int'(cnt), ec[k]);
        chk($sformatf("R1 seq dir %0d", k), int'(cnt_down), ed[k]);
        @(negedge clk);
      end
    end

    // compare shadow
    setup(10, 3, 7, 6, 6);
    en = 1'b1;
    wait_for(5, 1'b0);
    wr(1, 8);
    wait_for(4, 1'b1);
    chk("R3 old compare kept until zero", int'(pwm_a), 1);
    wait_for(5, 1'b0);
    chk("R3 new compare after zero", int'(pwm_a), 0);
    wait_for(9, 1'b0);
    chk("R3 new compare rise", int'(pwm_a), 1);

    // period shadow
    begin
      int mx;
      wait_for(5, 1'b0);
      wr(0, 4);
      mx = int'(cnt);
      while (cnt != 0) begin
        @(negedge clk);
        if (int'(cnt) > mx) mx = int'(cnt);
      end
      chk("R2 old period to zero", mx, 10);
      @(negedge clk);
      mx = 0;
      while (cnt != 0) begin
        if (int'(cnt) > mx) mx = int'(cnt);
        @(negedge clk);
      end
      chk("R2 new period after zero", mx, 4);
    end

    // trip
    begin
      int hi;
      setup(10, 3, 7, 6, 6);
      en = 1'b1;
      wait_for(8, 1'b0);
      trip_force = 1'b1;
      @(negedge clk);
      trip_force = 1'b0;
      chk("R9 force drops A", int'(pwm_a), 0);
      chk("R9 force drops B", int'(pwm_b), 0);
      hi = 0;
      repeat (40) begin @(negedge clk); hi += int'(pwm_a | pwm_b); end
      chk("R10 latched after force", hi, 0);
      trip_src = 1'b1;
      trip_clr = 1'b1;
      @(negedge clk);
      trip_clr = 1'b0;
      hi = 0;
      repeat (20) begin @(negedge clk); hi += int'(pwm_a | pwm_b); end
      chk("R10 clear ignored under source", hi, 0);
      trip_src = 1'b0;
      hi = 0;
      repeat (20) begin @(negedge clk); hi += int'(pwm_a | pwm_b); end
      chk("R10 latched after source drop", hi, 0);
      wait_for(8, 1'b0);
      trip_clr = 1'b1;
      @(negedge clk);
      trip_clr = 1'b0;
      chk("R11 A low after clear", int'(pwm_a), 0);
      chk("R11 B low after clear", int'(pwm_b), 0);
      wait_for(5, 1'b0);
      chk("R11 A resumes on match", int'(pwm_a), 1);
    end

    // disable mid-run
    wait_for(9, 1'b0);
    en = 1'b0;
    @(negedge clk);
    chk("R12 disable cnt", int'(cnt), 0);
    chk("R12 disable dir", int'(cnt_down), 1);
    chk("R12 disable pwm_a", int'(pwm_a), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule